// File: doc/BRIEF.md
# Bus Hold Handshake Controller

This block manages the hand-over of the local bus to another master. A master that wants the bus raises a hold request. The controller then lets every bus cycle already in flight finish, reported to it as an outstanding-cycle count. When none remain, it raises the acknowledge and drops the bus output-enable in the same clock, so that the other master finds the bus floating.

The bus stays released until the request is withdrawn. The acknowledge then falls and the output-enable returns. A cycle that was waiting to run is launched through a one-clock start strobe, exactly one clock after the acknowledge fell. While a locked sequence is running, the request is ignored. While reset is asserted, the request is still obeyed, and cycles still outstanding at that point are treated as abandoned. The sequencing of the bus cycles themselves is handled elsewhere.

Top module: `bus_hold_ctrl`

## Requirements
- R1: While `rst` is high with `hold_req` low, the next clock edge leaves the bus driven: `hold_ack`=0, `bus_oe`=1. `cyc_start` is 0 throughout reset.
- R2: While `rst` is high with `hold_req` high, the next clock edge raises `hold_ack` and clears `bus_oe`, whatever the value of `out_cnt`.
- R3: While `out_cnt` is non-zero, `hold_ack` does not rise. A recognized request is acknowledged on the edge after the clock in which `out_cnt` is 0.
- R4: `bus_oe` is always the inverse of `hold_ack`; both change on the same edge.
- R5: Once `hold_ack` is 1, it stays 1 as long as `hold_req` stays 1, whatever the value of `lock`.
- R6: With `hold_ack` at 1, a clock edge that sees `hold_req` at 0 clears `hold_ack` and sets `bus_oe`.
- R7: In the clock right after `hold_ack` falls, `cyc_start` is 0. In the clock after that, `cyc_start` equals `pend_req`.
- R8: `cyc_start` is 0 while the bus is released, while draining, and in a clock in which a request is being recognized.
- R9: A request seen in the driving state while `lock` is 1 is not recognized. The bus stays driven, and `cyc_start` follows `pend_req`.
- R10: While draining, a clock that sees `hold_req` at 0 or `lock` at 1 returns the block to driving without any acknowledge.
- R11: A request seen in the driving state with `lock` at 0 and `out_cnt` at 0 raises `hold_ack` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; hold requests are still obeyed during reset |
| hold_req | input | 1 | Bus hold request from the other master |
| lock | input | 1 | A locked bus sequence is in progress |
| out_cnt | input | CNT_W | Number of bus cycles still outstanding |
| pend_req | input | 1 | A new bus cycle is waiting to start |
| hold_ack | output | 1 | Hold acknowledge: the bus has been released |
| bus_oe | output | 1 | Output-enable for the bus drivers |
| cyc_start | output | 1 | One-clock strobe that launches the pending cycle |

## Verification
The hardest point to reach is the drain phase, because the request must arrive while cycles are still outstanding. The stimulus holds `out_cnt` non-zero over several clocks while `hold_req` is high. It then counts down, withdraws the request in the middle of a drain, and raises `lock` in the middle of a drain. In each of these cases the bench checks that the acknowledge arrives only when it should, and that no start leaks out. The clock gap between the fall of the acknowledge and the start strobe is checked with `pend_req` held high throughout, so that a start one clock early would show at the ports.

// File: rtl/bhh_pkg.sv
package bhh_pkg;

  typedef enum logic [1:0] {
    ST_DRIVE  = 2'd0,
    ST_DRAIN  = 2'd1,
    ST_HELD   = 2'd2,
    ST_RESUME = 2'd3
  } bhh_state_e;

  // A hold request counts only when no locked sequence masks it.
  function automatic logic hold_taken(input logic req, input logic lk);
    return req & ~lk;
  endfunction

endpackage

// File: rtl/bhh_fsm.sv
module bhh_fsm
  import bhh_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold_req,
  input  logic             lock,
  input  logic [CNT_W-1:0] out_cnt,
  output bhh_state_e       state,
  output logic             take_now
);

  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  function automatic logic drained(input logic [CNT_W-1:0] c);
    return c == CNT_ZERO;
  endfunction

  bhh_state_e nxt;
  logic       bus_idle;

  assign bus_idle = drained(out_cnt);
  assign take_now = (state == ST_DRIVE) && hold_taken(hold_req, lock);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_DRIVE:  if (take_now) nxt = bus_idle ? ST_HELD : ST_DRAIN;
      ST_DRAIN:  if (!hold_taken(hold_req, lock)) nxt = ST_DRIVE;
                 else if (bus_idle)               nxt = ST_HELD;
      ST_HELD:   if (!hold_req) nxt = ST_RESUME;
      ST_RESUME: nxt = ST_DRIVE;
      default:   nxt = ST_DRIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= hold_req ? ST_HELD : ST_DRIVE;
    else     state <= nxt;
  end

  // R3: outstanding cycles keep the bus from being released
  p_drain_blocks_r3: assert property (@(posedge clk) disable iff (rst)
    (state != ST_HELD && out_cnt != CNT_ZERO) |=> (state != ST_HELD));

  // R9: a locked sequence masks the request in the driving state
  p_lock_mask_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DRIVE && lock) |=> (state == ST_DRIVE));

  // R10: a drain is abandoned when the request goes or a lock starts
  p_drain_abort_r10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DRAIN && (!hold_req || lock)) |=> (state == ST_DRIVE));

endmodule

// File: rtl/bhh_outdec.sv
module bhh_outdec
  import bhh_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  bhh_state_e state,
  input  logic       take_now,
  input  logic       pend_req,
  output logic       hold_ack,
  output logic       bus_oe,
  output logic       cyc_start
);

  logic released;
  logic start_ok;

  assign released  = (state == ST_HELD);
  assign hold_ack  = released;
  assign bus_oe    = (state != ST_HELD);
  // A start is allowed only in the driving state, outside reset, and not
  // in a clock in which a hold request is being recognized.
  assign start_ok  = (state == ST_DRIVE) && !rst && !take_now;
  assign cyc_start = start_ok && pend_req;

  // R8: no cycle starts while draining or while the bus is released
  p_no_start_held_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DRAIN || state == ST_HELD) |-> !cyc_start);

  // R7: nothing starts in the clock right after the acknowledge falls
  p_start_gap_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_ack) |-> !cyc_start);

endmodule

// File: rtl/bus_hold_ctrl.sv
module bus_hold_ctrl
  import bhh_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold_req,
  input  logic             lock,
  input  logic [CNT_W-1:0] out_cnt,
  input  logic             pend_req,
  output logic             hold_ack,
  output logic             bus_oe,
  output logic             cyc_start
);

  bhh_state_e state;
  logic       take_now;

  bhh_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .hold_req (hold_req),
    .lock     (lock),
    .out_cnt  (out_cnt),
    .state    (state),
    .take_now (take_now)
  );

  bhh_outdec u_dec (
    .clk       (clk),
    .rst       (rst),
    .state     (state),
    .take_now  (take_now),
    .pend_req  (pend_req),
    .hold_ack  (hold_ack),
    .bus_oe    (bus_oe),
    .cyc_start (cyc_start)
  );

  // R4: the output-enable is the complement of the acknowledge
  p_oe_vs_ack_r4: assert property (@(posedge clk) disable iff (rst)
    bus_oe == !hold_ack);

  // R5: the acknowledge holds while the request holds
  p_ack_keep_r5: assert property (@(posedge clk) disable iff (rst)
    (hold_ack && hold_req) |=> hold_ack);

  // R6: withdrawing the request gives the bus back on the next edge
  p_release_r6: assert property (@(posedge clk) disable iff (rst)
    (hold_ack && !hold_req) |=> (!hold_ack && bus_oe));

endmodule

// File: tb/tb_bus_hold_ctrl.sv
module tb_bus_hold_ctrl;

  localparam int CNT_W = 4;

  logic             clk = 1'b0;
  logic             rst, hold_req, lock, pend_req;
  logic [CNT_W-1:0] out_cnt;
  logic             hold_ack, bus_oe, cyc_start;

  always #5 clk = ~clk;

  bus_hold_ctrl #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .hold_req(hold_req), .lock(lock),
    .out_cnt(out_cnt), .pend_req(pend_req),
    .hold_ack(hold_ack), .bus_oe(bus_oe), .cyc_start(cyc_start)
  );

  typedef struct {
    logic  ack;
    logic  oe;
    logic  st;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;

  // Driver: applies one clock of stimulus and queues the values expected
  // in that clock, before the next rising edge.
  task automatic step(input logic r, input logic h, input logic l,
                      input int c, input logic p,
                      input logic e_ack, input logic e_oe, input logic e_st,
                      input string tag);
    exp_t e;
    @(negedge clk);
    rst = r; hold_req = h; lock = l; out_cnt = CNT_W'(c); pend_req = p;
    e.ack = e_ack; e.oe = e_oe; e.st = e_st; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: pops each expected item and compares it away from the edge.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_chk++;
        if (hold_ack !== e.ack || bus_oe !== e.oe || cyc_start !== e.st) begin
          n_fail++;
          $display("FAIL %s: ack/oe/start actual %b%b%b expected %b%b%b",
                   e.tag, hold_ack, bus_oe, cyc_start, e.ack, e.oe, e.st);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; hold_req = 1'b0; lock = 1'b0; out_cnt = '0; pend_req = 1'b0;
    @(negedge clk);
    //   rst hold lock cnt pend | ack oe start
    step(1, 0, 0, 0, 1, 0, 1, 0, "R1");   // reset, driving, no start
    step(1, 1, 0, 3, 0, 0, 1, 0, "R1");   // hold in reset, count ignored
    step(1, 1, 0, 3, 0, 1, 0, 0, "R2");   // released during reset
    step(0, 1, 0, 0, 1, 1, 0, 0, "R8");   // held: start blocked
    step(0, 0, 0, 0, 1, 1, 0, 0, "R5");   // still held, request drops now
    step(0, 0, 0, 0, 1, 0, 1, 0, "R7");   // ack fell: no start yet
    step(0, 0, 0, 0, 1, 0, 1, 1, "R7");   // one clock later: start
    step(0, 1, 0, 2, 1, 0, 1, 0, "R8");   // request recognized: no start
    step(0, 1, 0, 1, 1, 0, 1, 0, "R3");   // draining, count 1
    step(0, 1, 0, 0, 0, 0, 1, 0, "R3");   // drained this clock
    step(0, 1, 0, 0, 0, 1, 0, 0, "R4");   // ack and oe swap together
    step(0, 0, 0, 0, 0, 1, 0, 0, "R6");   // withdraw
    step(0, 0, 0, 0, 0, 0, 1, 0, "R6");   // bus driven again
    step(0, 0, 0, 0, 0, 0, 1, 0, "R7");   // nothing pending: no start
    step(0, 1, 1, 0, 1, 0, 1, 1, "R9");   // locked: not recognized
    step(0, 1, 1, 0, 0, 0, 1, 0, "R9");
    step(0, 1, 0, 2, 0, 0, 1, 0, "R9");   // lock gone: recognized, drain
    step(0, 0, 0, 2, 1, 0, 1, 0, "R10");  // withdrawn mid-drain
    step(0, 0, 0, 0, 1, 0, 1, 1, "R10");  // back to driving, start
    step(0, 1, 0, 0, 1, 0, 1, 0, "R11");  // idle bus: direct release
    step(0, 1, 0, 0, 0, 1, 0, 0, "R11");
    step(0, 1, 1, 0, 0, 1, 0, 0, "R5");   // lock while held: stays held
    step(0, 0, 0, 0, 0, 1, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 0, 1, 0, "R6");
    step(0, 1, 0, 1, 0, 0, 1, 0, "R10");  // start a drain
    step(0, 1, 1, 1, 0, 0, 1, 0, "R10");  // lock mid-drain: abandon
    step(0, 1, 1, 0, 1, 0, 1, 1, "R10");  // driving, locked, start
    step(0, 0, 0, 0, 0, 0, 1, 0, "R1");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule